// File: doc/BRIEF.md
# SDRAM Low-Power Sequencer

This block owns the SDRAM clock-enable pin and the two low-power modes of the memory interface. When the interface falls idle, it starts a programmable countdown. The interface falls idle when an inter-command delay expires or when the read-data queue drains. If nothing disturbs the countdown, the block drops clock-enable and the device enters power-down. A command appearing in the command queue raises clock-enable again. The block then holds off the command gate for a programmable exit delay.

A level request puts the device into self-refresh. The block emits a one-cycle self-refresh command strobe and drops clock-enable in that same cycle. It then keeps the device in self-refresh for at least a programmable minimum residency. Once the request is withdrawn, clock-enable rises and a second programmable delay must pass before commands are released. All pin-facing outputs are registered on the falling clock edge. The command gate sees a single ready signal.

Top module: `sdram_lowpower_seq`

## Requirements
- R1: While reset is held, cke reads 1 and both sr_cmd and cmd_ready read 0. At the first falling edge after reset is released, cmd_ready reads 1.
- R2: An idle event is a pulse on delay_expired or on rd_fifo_drained. Suppose an idle event is presented while cmdq_empty is 1, mif_busy is 0 and cfg_pd_period is P (P > 0). Then cke first reads 0 at the falling edge P+1 clock cycles later, and it stays 0 while the command queue remains empty.
- R3: If mif_busy rises or cmdq_empty falls during the idle countdown, the countdown is abandoned. cke stays 1 and cmd_ready returns to 1.
- R4: A cfg_pd_period of 0 disables automatic power-down, so idle events leave cke at 1.
- R5: In power-down, a 0 on cmdq_empty raises cke at the falling edge that follows the first rising edge that samples it. cke does not change at that rising edge.
- R6: On power-down exit, cmd_ready rises exactly cfg_txp+1 cycles after cke rises.
- R7: If sr_req is 1 while the queue is empty and the interface is not busy, sr_cmd is 1 for exactly one cycle, and cke reads 0 in that same cycle.
- R8: In self-refresh, cke stays 0 while sr_req is 1, and command-queue activity has no effect on it. If sr_req is withdrawn early, cke rises exactly cfg_tesr+2 cycles after the sr_cmd strobe. If the minimum residency has already elapsed, cke rises one cycle after the withdrawal.
- R9: On self-refresh exit, cmd_ready rises exactly cfg_txsr+1 cycles after cke rises.
- R10: cmd_ready is never 1 while cke is 0, and it stays 0 during every exit delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pd_period | input | PD_W | Idle cycles before power-down; 0 disables |
| cfg_txp | input | DLY_W | Power-down exit delay in cycles |
| cfg_tesr | input | DLY_W | Minimum self-refresh residency in cycles |
| cfg_txsr | input | DLY_W | Self-refresh exit delay in cycles |
| delay_expired | input | 1 | Pulse: an inter-command delay timed out |
| rd_fifo_drained | input | 1 | Pulse: the read-data queue just emptied |
| mif_busy | input | 1 | Memory interface is transferring or timing |
| cmdq_empty | input | 1 | Command queue holds no command |
| sr_req | input | 1 | Level request to stay in self-refresh |
| cke | output | 1 | SDRAM clock-enable, falling-edge registered |
| sr_cmd | output | 1 | One-cycle self-refresh command strobe |
| cmd_ready | output | 1 | Commands may issue |

## Verification
The bench uses the default widths: an 8-bit idle period and 4-bit delays. This allows it to program the extreme values of both fields. The idle period runs from 1 up to the full count of 255, and the exit delay runs from 0 to 15. This exercises the single-cycle countdown, the longest countdown and the zero-length exit delay. The self-refresh residency is kept small, so the bench can test both an early withdrawal and a late withdrawal of the request in a short run.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

    typedef enum logic [2:0] {
        LP_ACTIVE,
        LP_PD_COUNT,
        LP_POWER_DOWN,
        LP_PD_EXIT,
        LP_SR_ENTRY,
        LP_SELF_REFRESH,
        LP_SR_EXIT
    } lp_state_e;

    typedef struct packed {
        logic cke;
        logic sr_cmd;
        logic ready;
    } lp_pins_t;

    localparam lp_pins_t PINS_RESET = '{cke: 1'b1, sr_cmd: 1'b0, ready: 1'b0};

    // Pin values presented to the device for each sequencer state
    function automatic lp_pins_t pins_for(input lp_state_e s);
        lp_pins_t p;
        p.cke    = !(s == LP_POWER_DOWN || s == LP_SR_ENTRY || s == LP_SELF_REFRESH);
        p.sr_cmd = (s == LP_SR_ENTRY);
        p.ready  = (s == LP_ACTIVE);
        return p;
    endfunction

endpackage

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - ONE;
    end

    assign expire = run && (cnt == ONE);

    AST_IDLE_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> load_val != '0);  // R4

    AST_IDLE_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        (load) |=> (cnt != '0));  // R2

endmodule

// File: rtl/lp_delay_timer.sv
module lp_delay_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);

    AST_DELAY_LOADED: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));  // R6

endmodule

// File: rtl/lp_pin_stage.sv
module lp_pin_stage
    import lp_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lp_state_e state,
    output lp_pins_t  pins
);
    always_ff @(negedge clk) begin
        if (rst)
            pins <= PINS_RESET;
        else
            pins <= pins_for(state);
    end

    AST_READY_NEEDS_CKE: assert property (@(negedge clk) disable iff (rst)
        pins.ready |-> pins.cke);  // R10

    AST_STROBE_ONE_CYCLE: assert property (@(negedge clk) disable iff (rst)
        pins.sr_cmd |=> !pins.sr_cmd);  // R7

    AST_STROBE_CKE_LOW: assert property (@(negedge clk) disable iff (rst)
        pins.sr_cmd |-> !pins.cke);  // R7

endmodule

// File: rtl/sdram_lowpower_seq.sv
module sdram_lowpower_seq
    import lp_seq_pkg::*;
#(
    parameter int PD_W  = 8,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PD_W-1:0]  cfg_pd_period,
    input  logic [DLY_W-1:0] cfg_txp,
    input  logic [DLY_W-1:0] cfg_tesr,
    input  logic [DLY_W-1:0] cfg_txsr,
    input  logic             delay_expired,
    input  logic             rd_fifo_drained,
    input  logic             mif_busy,
    input  logic             cmdq_empty,
    input  logic             sr_req,
    output logic             cke,
    output logic             sr_cmd,
    output logic             cmd_ready
);
    lp_state_e        state_q, state_d;
    logic             idle_load, idle_run, idle_expire;
    logic             dly_load, dly_zero;
    logic [DLY_W-1:0] dly_val;
    logic             idle_evt, quiet;
    lp_pins_t         pins;

    assign idle_evt = delay_expired | rd_fifo_drained;
    assign quiet    = cmdq_empty & ~mif_busy;
    assign idle_run = (state_q == LP_PD_COUNT);

    always_comb begin
        state_d   = state_q;
        idle_load = 1'b0;
        dly_load  = 1'b0;
        dly_val   = '0;
        case (state_q)
            LP_ACTIVE: begin
                if (sr_req && quiet) begin
                    state_d = LP_SR_ENTRY;
                end else if (idle_evt && quiet && cfg_pd_period != '0) begin
                    state_d   = LP_PD_COUNT;
                    idle_load = 1'b1;
                end
            end
            LP_PD_COUNT: begin
                if (!quiet)
                    state_d = LP_ACTIVE;
                else if (sr_req)
                    state_d = LP_SR_ENTRY;
                else if (idle_expire)
                    state_d = LP_POWER_DOWN;
            end
            LP_POWER_DOWN: begin
                if (!cmdq_empty) begin
                    state_d  = LP_PD_EXIT;
                    dly_load = 1'b1;
                    dly_val  = cfg_txp;
                end
            end
            LP_PD_EXIT: begin
                if (dly_zero)
                    state_d = LP_ACTIVE;
            end
            LP_SR_ENTRY: begin
                state_d  = LP_SELF_REFRESH;
                dly_load = 1'b1;
                dly_val  = cfg_tesr;
            end
            LP_SELF_REFRESH: begin
                if (dly_zero && !sr_req) begin
                    state_d  = LP_SR_EXIT;
                    dly_load = 1'b1;
                    dly_val  = cfg_txsr;
                end
            end
            LP_SR_EXIT: begin
                if (dly_zero)
                    state_d = LP_ACTIVE;
            end
            default: state_d = LP_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= LP_ACTIVE;
        else
            state_q <= state_d;
    end

    lp_idle_timer #(.W(PD_W)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .load     (idle_load),
        .run      (idle_run),
        .load_val (cfg_pd_period),
        .expire   (idle_expire)
    );

    lp_delay_timer #(.W(DLY_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (dly_val),
        .zero     (dly_zero)
    );

    lp_pin_stage u_pins (
        .clk   (clk),
        .rst   (rst),
        .state (state_q),
        .pins  (pins)
    );

    assign cke       = pins.cke;
    assign sr_cmd    = pins.sr_cmd;
    assign cmd_ready = pins.ready;

    AST_NO_AUTO_PD: assert property (@(posedge clk) disable iff (rst)
        (state_q == LP_ACTIVE && cfg_pd_period == '0) |=> state_q != LP_PD_COUNT);  // R4

    AST_COUNT_ABORT: assert property (@(posedge clk) disable iff (rst)
        (state_q == LP_PD_COUNT && !cmdq_empty) |=> state_q == LP_ACTIVE);  // R3

    AST_PD_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state_q == LP_POWER_DOWN && !cmdq_empty) |=> state_q == LP_PD_EXIT);  // R5

    AST_PD_EXIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == LP_PD_EXIT && !dly_zero) |=> state_q == LP_PD_EXIT);  // R6

    AST_SR_RESIDENCY: assert property (@(posedge clk) disable iff (rst)
        (state_q == LP_SELF_REFRESH && (!dly_zero || sr_req)) |=> state_q == LP_SELF_REFRESH);  // R8

    AST_SR_EXIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == LP_SR_EXIT && !dly_zero) |=> state_q == LP_SR_EXIT);  // R9

endmodule

// File: tb/sdram_lowpower_seq_test.sv
module sdram_lowpower_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_pd_period = 8'd4;
    logic [3:0] cfg_txp  = 4'd2;
    logic [3:0] cfg_tesr = 4'd3;
    logic [3:0] cfg_txsr = 4'd5;
    logic       delay_expired = 1'b0;
    logic       rd_fifo_drained = 1'b0;
    logic       mif_busy = 1'b0;
    logic       cmdq_empty = 1'b1;
    logic       sr_req = 1'b0;
    logic       cke, sr_cmd, cmd_ready;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    sdram_lowpower_seq uut (
        .clk             (clk),
        .rst             (rst),
        .cfg_pd_period   (cfg_pd_period),
        .cfg_txp         (cfg_txp),
        .cfg_tesr        (cfg_tesr),
        .cfg_txsr        (cfg_txsr),
        .delay_expired   (delay_expired),
        .rd_fifo_drained (rd_fifo_drained),
        .mif_busy        (mif_busy),
        .cmdq_empty      (cmdq_empty),
        .sr_req          (sr_req),
        .cke             (cke),
        .sr_cmd          (sr_cmd),
        .cmd_ready       (cmd_ready)
    );

    // vector: [15:8] idle period, [7] event select (1 = read queue drained), [3:0] exit delay
    localparam int NVEC = 4;
    localparam logic [15:0] VEC [NVEC] = '{
        {8'd1,   1'b0, 3'd0, 4'd0},
        {8'd3,   1'b1, 3'd0, 4'd2},
        {8'd7,   1'b0, 3'd0, 4'd15},
        {8'd255, 1'b1, 3'd0, 4'd5}
    };

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // advance one cycle, clearing event pulses, then sample after the falling edge
    task automatic step();
        @(negedge clk);
        delay_expired   = 1'b0;
        rd_fifo_drained = 1'b0;
        #1;
    endtask

    // which: 0 = cke, 1 = cmd_ready, 2 = sr_cmd
    task automatic wait_for(input int which, input logic val, output int n);
        logic cur;
        n = 0;
        do begin
            step();
            n++;
            cur = (which == 0) ? cke : (which == 1) ? cmd_ready : sr_cmd;
        end while (cur !== val && n < 600);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic cke_low_seen;

        // R1: values under reset
        repeat (3) @(negedge clk);
        #1;
        chk_bit("R1 cke in reset", cke, 1'b1);
        chk_bit("R1 sr_cmd in reset", sr_cmd, 1'b0);
        chk_bit("R1 ready in reset", cmd_ready, 1'b0);
        rst = 1'b0;
        step();
        chk_bit("R1 ready after reset", cmd_ready, 1'b1);
        chk_bit("R1 cke after reset", cke, 1'b1);

        // vector loop: power-down entry and exit
        for (int i = 0; i < NVEC; i++) begin
            cfg_pd_period = VEC[i][15:8];
            cfg_txp       = VEC[i][3:0];
            step();
            if (VEC[i][7]) rd_fifo_drained = 1'b1;
            else           delay_expired   = 1'b1;
            wait_for(0, 1'b0, n);
            chk_int("R2 cke fall latency", n, int'(VEC[i][15:8]) + 1);
            repeat (3) step();
            chk_bit("R2 cke held low", cke, 1'b0);
            chk_bit("R10 no ready in power-down", cmd_ready, 1'b0);
            cmdq_empty = 1'b0;
            @(posedge clk);
            #1;
            chk_bit("R5 cke unchanged at rising edge", cke, 1'b0);
            step();
            chk_bit("R5 cke raised at falling edge", cke, 1'b1);
            chk_bit("R10 ready held during exit", cmd_ready, 1'b0);
            wait_for(1, 1'b1, n);
            chk_int("R6 ready after exit delay", n, int'(VEC[i][3:0]) + 1);
            cmdq_empty = 1'b1;
            step();
        end

        // R3: busy aborts the countdown
        cfg_pd_period = 8'd10;
        cfg_txp = 4'd2;
        delay_expired = 1'b1;
        repeat (3) step();
        mif_busy = 1'b1;
        cke_low_seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            step();
            if (cke !== 1'b1) cke_low_seen = 1'b1;
        end
        chk_bit("R3 busy abort keeps cke high", cke_low_seen, 1'b0);
        mif_busy = 1'b0;
        repeat (2) step();
        chk_bit("R3 ready back after abort", cmd_ready, 1'b1);

        // R3: command arrival aborts the countdown
        rd_fifo_drained = 1'b1;
        repeat (2) step();
        cmdq_empty = 1'b0;
        step();
        cmdq_empty = 1'b1;
        cke_low_seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            step();
            if (cke !== 1'b1) cke_low_seen = 1'b1;
        end
        chk_bit("R3 command abort keeps cke high", cke_low_seen, 1'b0);
        chk_bit("R3 ready after command abort", cmd_ready, 1'b1);

        // R4: zero period disables power-down
        cfg_pd_period = 8'd0;
        rd_fifo_drained = 1'b1;
        cke_low_seen = 1'b0;
        for (int k = 0; k < 30; k++) begin
            step();
            if (cke !== 1'b1) cke_low_seen = 1'b1;
        end
        chk_bit("R4 no power-down with zero period", cke_low_seen, 1'b0);
        chk_bit("R4 ready stays high", cmd_ready, 1'b1);

        // R7, R8, R9: self-refresh held long, then late wake
        cfg_tesr = 4'd3;
        cfg_txsr = 4'd5;
        sr_req = 1'b1;
        wait_for(2, 1'b1, n);
        chk_bit("R7 strobe seen", sr_cmd, 1'b1);
        chk_bit("R7 cke low with strobe", cke, 1'b0);
        step();
        chk_bit("R7 strobe single cycle", sr_cmd, 1'b0);
        chk_bit("R8 cke low in self-refresh", cke, 1'b0);
        repeat (4) step();
        cmdq_empty = 1'b0;
        cke_low_seen = 1'b1;
        for (int k = 0; k < 15; k++) begin
            step();
            if (cke !== 1'b0 || cmd_ready !== 1'b0) cke_low_seen = 1'b0;
        end
        chk_bit("R8 command ignored in self-refresh", cke_low_seen, 1'b1);
        cmdq_empty = 1'b1;
        step();
        sr_req = 1'b0;
        wait_for(0, 1'b1, n);
        chk_int("R8 late wake latency", n, 1);
        wait_for(1, 1'b1, n);
        chk_int("R9 ready after exit delay", n, 5 + 1);
        step();

        // R8, R9: early withdrawal honours minimum residency
        cfg_tesr = 4'd6;
        cfg_txsr = 4'd0;
        sr_req = 1'b1;
        wait_for(2, 1'b1, n);
        sr_req = 1'b0;
        wait_for(0, 1'b1, n);
        chk_int("R8 minimum residency", n, 6 + 2);
        wait_for(1, 1'b1, n);
        chk_int("R9 ready with zero exit delay", n, 1);
        chk_bit("R10 cke high with ready", cke, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule